// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

This block is an 8-bit up-counter driven by a free-running prescaler on the bus clock. Software picks one of eight divider taps as the count rate, and a mode bit decides what an overflow means. In watchdog mode, software must rewrite the counter before it wraps. If it does not, the overflow output pulses for a fixed time and, when enabled, a reset request pulses with it. In interval mode the counter runs freely, and each wrap sets a sticky flag that can raise an interrupt request.

Software reaches three byte registers through a simple bus with a combinational read path. Address 0 is the control/status register: bit 7 is the interval flag, bit 6 the mode (1 = watchdog, 0 = interval), bit 5 the run enable, bit 4 the interrupt enable, and bits 2:0 the tap select. Address 1 is the counter. Address 2 is the reset control/status register: bit 7 is the watchdog overflow flag and bit 6 the reset-request enable. Unused bits and address 3 read as zero. A flag is cleared by a write of 0 to its bit, and that write only takes effect after a read strobe (`bus_rd`) has returned the flag as 1.

Top module: `wdog_itimer`

## Requirements
- R1: After reset, all three registers read 0x00 and `irq_o`, `wdt_ovf_o` and `rst_req_o` are low.
- R2: While the run bit is 0, the counter and prescaler are held at zero, and a write to the counter has no effect.
- R3: Tap select values 0 to 7 divide the bus clock by 2, 64, 128, 512, 2048, 8192, 32768 and 131072. With tap divisor 2·2^b, the first increment lands 2^b+1 clocks after the write that sets the run bit.
- R4: At each count tick the counter goes up by one. From 0xFF it wraps to 0x00, which is the overflow, and it keeps counting afterwards.
- R5: In interval mode, an overflow sets control bit 7, and `irq_o` equals that flag ANDed with control bit 4.
- R6: A flag is cleared only by writing 0 to its bit after a read strobe has returned it as 1. A write of 0 with no such read leaves it set, and a write of 1 never sets it.
- R7: In watchdog mode, an overflow sets reset-register bit 7 and drives `wdt_ovf_o` high for exactly 128 clocks. It does not set the interval flag.
- R8: `rst_req_o` pulses together with `wdt_ovf_o` only when reset-register bit 6 is 1.
- R9: A counter write in the same cycle as a count tick loads the written value, and the tick is lost.
- R10: Rewriting the counter often enough in watchdog mode stops any overflow from occurring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flag clearing) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq_o | output | 1 | Interval interrupt request |
| wdt_ovf_o | output | 1 | Watchdog overflow pulse |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
Every tap is timed to its first increment in exact clocks. A wrong tap bit, or a missed edge, changes that count by a whole power of two. The bench writes the counter on a tick edge; a design that let the tick win would read one count high. It also tries to clear a flag without a prior read, which a design lacking the arm step would let through. The watchdog pulse is measured clock by clock, so an off-by-one pulse length, a reset request that ignores its enable, or a watchdog wrap that sets the interval flag all show up.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int CNT_W     = 8;
    localparam int DIV_W     = 17;
    localparam int SEL_W     = 3;
    localparam int PULSE_LEN = 128;

    localparam logic [1:0] A_CTL = 2'd0;
    localparam logic [1:0] A_CNT = 2'd1;
    localparam logic [1:0] A_RST = 2'd2;

    typedef struct packed {
        logic             wd_mode;
        logic             run;
        logic             ie;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    // divider bit whose rising edge forms the count tick
    function automatic int tap_bit(input logic [SEL_W-1:0] s);
        case (s)
            3'd0:    return 0;
            3'd1:    return 5;
            3'd2:    return 6;
            3'd3:    return 8;
            3'd4:    return 10;
            3'd5:    return 12;
            3'd6:    return 14;
            default: return 16;
        endcase
    endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
    import wdog_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [DW-1:0] div;
    logic          prev;
    logic          tap;

    always_comb tap = div[tap_bit(sel)];

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div  <= '0;
            prev <= 1'b0;
        end else begin
            div  <= div + 1'b1;
            prev <= tap;
        end
    end

    assign tick = run & tap & ~prev;

    assert_tick_single_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (wr)     cnt <= wdata;
        else if (tick)   cnt <= cnt + 1'b1;
    end

    assign ovf = run & tick & ~wr & (cnt == MAXV);

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (run && wr) |=> cnt == $past(wdata));
    assert_hold_clear_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int LEN = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic pulse_o
);
    localparam int PW = $clog2(LEN + 1);
    localparam logic [PW-1:0] LOADV = PW'(LEN);

    logic [PW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)               left <= '0;
        else if (trig)         left <= LOADV;
        else if (left != '0)   left <= left - 1'b1;
    end

    assign pulse_o = (left != '0);

    assert_pulse_start_R7: assert property (@(posedge clk) disable iff (rst)
        trig |=> pulse_o);
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (rst)
        (!trig && !pulse_o) |=> !pulse_o);
endmodule

// File: rtl/wdog_itimer.sv
module wdog_itimer
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq_o,
    output logic             wdt_ovf_o,
    output logic             rst_req_o
);
    ctl_t             ctl;
    logic             iflag, iarm, wflag, warm, rst_en;
    logic             tick, ovf, ovf_pulse;
    logic [CNT_W-1:0] cnt;
    logic             wr_ctl, wr_cnt, wr_rst, iclr, wclr;

    always_comb begin
        wr_ctl = bus_wr && bus_addr == A_CTL;
        wr_cnt = bus_wr && bus_addr == A_CNT;
        wr_rst = bus_wr && bus_addr == A_RST;
        iclr   = wr_ctl && !bus_wdata[7] && iarm;
        wclr   = wr_rst && !bus_wdata[7] && warm;
    end

    wdog_prescaler u_pre (
        .clk(clk), .rst(rst), .run(ctl.run), .sel(ctl.sel), .tick(tick)
    );

    wdog_counter u_cnt (
        .clk(clk), .rst(rst), .run(ctl.run), .tick(tick),
        .wr(wr_cnt), .wdata(bus_wdata), .cnt(cnt), .ovf(ovf)
    );

    wdog_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst(rst), .trig(ovf && ctl.wd_mode), .pulse_o(ovf_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '0;
            rst_en <= 1'b0;
            iflag  <= 1'b0;
            iarm   <= 1'b0;
            wflag  <= 1'b0;
            warm   <= 1'b0;
        end else begin
            if (wr_ctl) ctl <= '{wd_mode: bus_wdata[6], run: bus_wdata[5],
                                 ie: bus_wdata[4], sel: bus_wdata[2:0]};
            if (wr_rst) rst_en <= bus_wdata[6];
            // set beats clear when both land in one cycle
            if (ovf && !ctl.wd_mode) iflag <= 1'b1;
            else if (iclr)           iflag <= 1'b0;
            if (ovf && ctl.wd_mode)  wflag <= 1'b1;
            else if (wclr)           wflag <= 1'b0;
            if (iclr)                                     iarm <= 1'b0;
            else if (bus_rd && bus_addr == A_CTL && iflag) iarm <= 1'b1;
            if (wclr)                                     warm <= 1'b0;
            else if (bus_rd && bus_addr == A_RST && wflag) warm <= 1'b1;
        end
    end

    always_comb begin
        case (bus_addr)
            A_CTL:   bus_rdata = {iflag, ctl.wd_mode, ctl.run, ctl.ie, 1'b0, ctl.sel};
            A_CNT:   bus_rdata = cnt;
            A_RST:   bus_rdata = {wflag, rst_en, 6'b0};
            default: bus_rdata = '0;
        endcase
    end

    assign irq_o     = iflag & ctl.ie;
    assign wdt_ovf_o = ovf_pulse;
    assign rst_req_o = ovf_pulse & rst_en;

    assert_rst_with_ovf_R8: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> wdt_ovf_o);
    assert_ovf_watchdog_only_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_ovf_o) |-> $past(ctl.wd_mode));
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (iflag && !wr_ctl) |=> iflag);
    assert_wflag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (wflag && !wr_rst) |=> wflag);
endmodule

// File: tb/wdog_itimer_test.sv
module wdog_itimer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_o, wdt_ovf_o, rst_req_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    wdog_itimer uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .wdt_ovf_o(wdt_ovf_o), .rst_req_o(rst_req_o)
    );

    // tap select vs clocks to first increment (2^b + 1)
    localparam int NTAP = 8;
    localparam int TAP_SEL [NTAP] = '{0, 1, 2, 3, 4, 5, 6, 7};
    localparam int TAP_EXP [NTAP] = '{2, 33, 65, 257, 1025, 4097, 16385, 65537};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        edges(2);
        rst = 1'b0;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        peek(2'd0, rv); chk("R1 ctl", rv, 8'h00);
        peek(2'd1, rv); chk("R1 cnt", rv, 8'h00);
        peek(2'd2, rv); chk("R1 rstctl", rv, 8'h00);
        chk("R1 outputs", {irq_o, wdt_ovf_o, rst_req_o}, 0);

        // R2 counter held while not running
        wr(2'd1, 8'h55);
        edges(5);
        peek(2'd1, rv); chk("R2 write ignored while stopped", rv, 8'h00);

        // R3 tap table walk
        for (int k = 0; k < NTAP; k++) begin
            int n;
            wr(2'd0, 8'h00);
            wr(2'd0, 8'h20 | TAP_SEL[k][7:0]);
            n = 0;
            do begin
                edges(1); n++;
                peek(2'd1, rv);
            end while (rv == 8'h00 && n < 70000);
            chk($sformatf("R3 tap %0d first increment", k), n, TAP_EXP[k]);
        end

        // R9 write wins over a tick (div by 2, ticks at E2, E4, E6)
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h20);
        edges(3);
        wr(2'd1, 8'h10);
        peek(2'd1, rv); chk("R9 write on tick edge", rv, 8'h10);
        edges(2);
        peek(2'd1, rv); chk("R9 next tick counts on", rv, 8'h11);

        // R4 R5 interval overflow with interrupt enabled
        do_reset();
        wr(2'd0, 8'h30);
        wr(2'd1, 8'hFE);
        edges(1);
        peek(2'd1, rv); chk("R4 count to FF", rv, 8'hFF);
        chk("R5 no irq before wrap", irq_o, 0);
        edges(2);
        peek(2'd1, rv); chk("R4 wrap to 00", rv, 8'h00);
        chk("R5 irq on wrap", irq_o, 1);
        chk("R7 no ovf pulse in interval mode", wdt_ovf_o, 0);
        edges(2);
        peek(2'd1, rv); chk("R4 keeps counting", rv, 8'h01);

        // R6 clear protocol
        wr(2'd0, 8'h30);
        peek(2'd0, rv); chk("R6 clear without read ignored", rv[7], 1);
        rd(2'd0, rv);
        wr(2'd0, 8'hB0);
        peek(2'd0, rv); chk("R6 write 1 keeps flag", rv[7], 1);
        wr(2'd0, 8'h30);
        peek(2'd0, rv); chk("R6 clear after read", rv[7], 0);
        chk("R5 irq drops with flag", irq_o, 0);

        // R5 interrupt enable masks the request
        wr(2'd0, 8'h20);
        begin
            int n = 0;
            do begin edges(1); n++; peek(2'd0, rv); end while (!rv[7] && n < 600);
        end
        chk("R5 flag set with ie off", rv[7], 1);
        chk("R5 irq masked", irq_o, 0);

        // R7 R8 watchdog with reset request enabled
        do_reset();
        wr(2'd2, 8'h40);
        wr(2'd0, 8'h60);
        wr(2'd1, 8'hFE);
        edges(2);
        chk("R7 no pulse before wrap", wdt_ovf_o, 0);
        edges(1);
        chk("R7 ovf pulse starts", wdt_ovf_o, 1);
        chk("R8 reset request with enable", rst_req_o, 1);
        peek(2'd2, rv); chk("R7 watchdog flag", rv, 8'hC0);
        peek(2'd0, rv); chk("R7 interval flag untouched", rv[7], 0);
        chk("R7 no irq", irq_o, 0);
        begin
            int n = 1;
            int m = 1;
            while (n < 300) begin
                edges(1);
                if (!wdt_ovf_o) break;
                n++;
                if (rst_req_o) m++;
            end
            chk("R7 pulse length", n, 128);
            chk("R8 reset pulse length", m, 128);
        end

        // R6 watchdog flag clear protocol
        wr(2'd2, 8'h40);
        peek(2'd2, rv); chk("R6 wflag needs read", rv[7], 1);
        rd(2'd2, rv);
        wr(2'd2, 8'h40);
        peek(2'd2, rv); chk("R6 wflag cleared", rv[7], 0);

        // R8 reset request disabled
        do_reset();
        wr(2'd0, 8'h60);
        wr(2'd1, 8'hFE);
        edges(3);
        chk("R8 ovf without enable", wdt_ovf_o, 1);
        chk("R8 no reset request", rst_req_o, 0);

        // R10 kicking prevents overflow
        do_reset();
        wr(2'd0, 8'h60);
        begin
            int seen = 0;
            for (int k = 0; k < 10; k++) begin
                for (int i = 0; i < 200; i++) begin
                    edges(1);
                    if (wdt_ovf_o) seen = 1;
                end
                wr(2'd1, 8'h00);
            end
            chk("R10 no overflow while kicked", seen, 0);
            seen = 0;
            for (int i = 0; i < 600; i++) begin
                edges(1);
                if (wdt_ovf_o) seen = 1;
            end
            chk("R10 overflow once kicks stop", seen, 1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule